// File: doc/BRIEF.md
# Bus controller message sequencer

This block runs one command/response message as the controlling end of a word-level serial bus. Serial encoding and analog timing live outside it. On a start event it sends the first command word, and also a second command word when the message is a terminal-to-terminal transfer. When the command asks the terminal to receive, it then sends data words drawn from a transmit FIFO. After that it waits for the responder's status word and any data words, and writes the received data into a receive FIFO that the host drains.

Every message ends with exactly one of two held flags: message good or message failed. A failed message also sets one cause bit in an error register. A good message can still be turned into a failed one afterwards: this happens if a data word arrives that the command never asked for. The transmit FIFO is emptied whenever either end flag is raised, so the next message starts from fresh data.

Command words use the field layout that the bus defines:
- bits 15:11 hold the terminal address.
- bit 10 is the direction, where 1 means the terminal transmits.
- bits 9:5 hold the subaddress.
- bits 4:0 hold the count or mode code.

Status words carry the responder's address in bits 15:11.

Top module: `bc_msg_seq`

## Requirements
- R1: A sequence starts on a rising edge of `start_i`, or on a 0-to-1 change of `start_ctl_i`, while `busy_o` is low. Holding `start_ctl_i` high does not start another sequence.
- R2: For a receive command (bit 10 = 0, subaddress neither 0 nor 31), `cmd1_i` goes out with command sync (`tx_csync_o` = 1). It is followed by N data words popped from the transmit FIFO with `tx_csync_o` = 0. N is the count field, and a value of 0 means 32. Sending stalls while the transmit FIFO is empty.
- R3: For a transmit command (bit 10 = 1), the status word is captured in `stat1_o`. The following N data words are written into the receive FIFO.
- R4: A subaddress of 0 or 31 marks a mode code. If code bit 4 is 1, the mode code carries one data word: it is sent from the transmit FIFO before the status for a receive command, and stored after the status for a transmit command. If code bit 4 is 0, no data word is exchanged.
- R5: With `rt_rt_i` high, `cmd1_i` (the receive command) and then `cmd2_i` (the transmit command) are sent. The first status word must carry the address from `cmd2_i` and goes to `stat2_o`. Then come N data words, with N taken from `cmd2_i`. A second status word follows, must carry the address from `cmd1_i`, and goes to `stat1_o`.
- R6: Each sequence ends with exactly one of `msg_ok_o` or `msg_err_o` high. The flag is held until the next start. Both flags and `err_o` are cleared when a sequence starts.
- R7: If no word arrives within RESP_TO cycles while a status word is awaited, the message fails with `err_o` bit 0 set.
- R8: A received word marked by `rx_bad_i` fails the message with `err_o` bit 1 set, and it is not stored.
- R9: A status word whose bits 15:11 differ from the expected address fails the message with `err_o` bit 3 set. The word is still captured.
- R10: Word-count errors set `err_o` bit 2. This covers a command-sync word arriving where a data word is due. It also covers a data-sync word arriving while idle after a good message: that clears `msg_ok_o` and raises `msg_err_o`.
- R11: Breaks in continuity set `err_o` bit 4. This covers a data word due but no word arriving for GAP_TO cycles. It also covers a data-sync word arriving where a status word is due.
- R12: The transmit FIFO is emptied in the cycle either end flag is raised, and any words left in it are discarded.
- R13: The receive FIFO holds FIFO_DEPTH words. A read while it is not empty pops the word shown on `rxf_word_o`. Words that arrive while it is full are dropped. `rxf_empty_o` is high when it holds nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, rising edge |
| start_ctl_i | input | 1 | Start control bit, acts on a 0-to-1 change |
| rt_rt_i | input | 1 | Selects terminal-to-terminal transfer |
| cmd1_i | input | 16 | First command word |
| cmd2_i | input | 16 | Second (transmit) command word |
| txf_we_i | input | 1 | Transmit FIFO write |
| txf_wdata_i | input | 16 | Transmit FIFO write data |
| txf_full_o | output | 1 | Transmit FIFO full |
| tx_valid_o | output | 1 | Outgoing word valid this cycle |
| tx_word_o | output | 16 | Outgoing word |
| tx_csync_o | output | 1 | Outgoing word uses command sync |
| rx_valid_i | input | 1 | Incoming word valid |
| rx_word_i | input | 16 | Incoming word |
| rx_csync_i | input | 1 | Incoming word had command/status sync |
| rx_bad_i | input | 1 | Incoming word failed parity or encoding |
| rxf_re_i | input | 1 | Receive FIFO read |
| rxf_word_o | output | 16 | Receive FIFO head word |
| rxf_empty_o | output | 1 | Receive FIFO empty |
| stat1_o | output | 16 | Captured status word 1 |
| stat2_o | output | 16 | Captured status word 2 |
| busy_o | output | 1 | Sequence in progress |
| msg_ok_o | output | 1 | Message good flag |
| msg_err_o | output | 1 | Message failed flag |
| err_o | output | 5 | Error causes: 0 no response, 1 parity, 2 word count, 3 address, 4 continuity |

## Verification
Some properties are checked on every cycle. The two end flags must never be high together, and both must stay low while a sequence runs. The first cycle of a sequence must present the latched first command with command sync. The transmit FIFO must be empty whenever an end flag rises, and a withdrawn good flag must leave the failed flag and the word-count bit behind. Both wait timers and the FIFO occupancy must stay within bounds. The scenarios alone show the rest: word order on the outgoing side for each command kind, stalling on an empty transmit FIFO, the count field's 0-means-32 case, which error bit each fault selects, and words dropped at a full receive FIFO.

// File: rtl/bc_seq_pkg.sv
package bc_seq_pkg;
  typedef enum logic [2:0] {S_IDLE, S_CMD1, S_CMD2, S_TXD, S_WSTAT, S_RXD} seq_st_e;

  localparam int unsigned ERR_W     = 5;
  localparam int unsigned EB_NORESP = 0;
  localparam int unsigned EB_PARITY = 1;
  localparam int unsigned EB_WCOUNT = 2;
  localparam int unsigned EB_ADDR   = 3;
  localparam int unsigned EB_CONTIG = 4;

  typedef struct packed {
    logic [4:0] rt;
    logic       tx;
    logic [4:0] sa;
    logic [4:0] cnt;
  } cmd_word_t;

  function automatic logic [5:0] word_count(input logic [4:0] f);
    return (f == 5'd0) ? 6'd32 : {1'b0, f};
  endfunction

  function automatic logic is_mode(input logic [4:0] sa);
    return (sa == 5'd0) || (sa == 5'h1f);
  endfunction
endpackage

// File: rtl/bc_fifo.sv
module bc_fifo #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         re_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;
  logic          do_w, do_r;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign do_w    = we_i & ~full_o;
  assign do_r    = re_i & ~empty_o;
  assign rdata_o = mem_q[rp_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_w) wp_q <= nxt(wp_q);
      if (do_r) rp_q <= nxt(rp_q);
      case ({do_w, do_r})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_w && !clr_i) mem_q[wp_q] <= wdata_i;
  end

  a_r13_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= (AW+1)'(DEPTH));
  a_r13_full_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !re_i && !clr_i) |=> full_o);
endmodule

// File: rtl/bc_edge_det.sv
module bc_edge_det #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic         pulse_o
);
  logic [N-1:0] q;
  logic [N-1:0] rise;

  for (genvar i = 0; i < N; i++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q[i] <= 1'b0;
      else         q[i] <= lvl_i[i];
    end
    assign rise[i] = lvl_i[i] & ~q[i];
  end

  assign pulse_o = |rise;
endmodule

// File: rtl/bc_wait_timer.sv
module bc_wait_timer #(
  parameter int unsigned LIMIT = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  output logic expired_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!run_i || restart_i) cnt_q <= '0;
    else if (!expired_o)          cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == CW'(LIMIT));

  a_r7_timer_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(LIMIT));
  a_r11_idle_timer_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/bc_msg_seq.sv
module bc_msg_seq
  import bc_seq_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 32,
  parameter int unsigned RESP_TO    = 64,
  parameter int unsigned GAP_TO     = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             start_ctl_i,
  input  logic             rt_rt_i,
  input  logic [15:0]      cmd1_i,
  input  logic [15:0]      cmd2_i,
  input  logic             txf_we_i,
  input  logic [15:0]      txf_wdata_i,
  output logic             txf_full_o,
  output logic             tx_valid_o,
  output logic [15:0]      tx_word_o,
  output logic             tx_csync_o,
  input  logic             rx_valid_i,
  input  logic [15:0]      rx_word_i,
  input  logic             rx_csync_i,
  input  logic             rx_bad_i,
  input  logic             rxf_re_i,
  output logic [15:0]      rxf_word_o,
  output logic             rxf_empty_o,
  output logic [15:0]      stat1_o,
  output logic [15:0]      stat2_o,
  output logic             busy_o,
  output logic             msg_ok_o,
  output logic             msg_err_o,
  output logic [ERR_W-1:0] err_o
);
  seq_st_e    st_q, st_d;
  logic [5:0] cnt_q, cnt_d;
  logic       phase_q, phase_d;
  cmd_word_t  cmd1_q, cmd2_q;
  logic       rt2rt_q;
  logic       ok_q, err_q;
  logic [ERR_W-1:0] ebits_q, eset;
  logic [15:0] stat1_q, stat2_q;

  logic start_p, start_go;
  logic set_ok, set_err, cap1, cap2;
  logic resp_exp, gap_exp;
  logic txf_empty, txf_re, txf_clr;
  logic [15:0] txf_rdata;
  logic rxf_we, rxf_full;
  logic mode1, mdat;
  logic [5:0] tx_n, rx_n;
  logic [4:0] exp_addr;

  bc_edge_det #(.N(2)) u_start (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .lvl_i({start_ctl_i, start_i}), .pulse_o(start_p)
  );

  bc_wait_timer #(.LIMIT(RESP_TO)) u_resp_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .run_i(st_q == S_WSTAT), .restart_i(rx_valid_i), .expired_o(resp_exp)
  );

  bc_wait_timer #(.LIMIT(GAP_TO)) u_gap_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .run_i(st_q == S_RXD), .restart_i(rx_valid_i), .expired_o(gap_exp)
  );

  bc_fifo #(.W(16), .DEPTH(FIFO_DEPTH)) u_txf (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(txf_clr),
    .we_i(txf_we_i), .wdata_i(txf_wdata_i),
    .re_i(txf_re), .rdata_o(txf_rdata),
    .empty_o(txf_empty), .full_o(txf_full_o)
  );

  bc_fifo #(.W(16), .DEPTH(FIFO_DEPTH)) u_rxf (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(1'b0),
    .we_i(rxf_we), .wdata_i(rx_word_i),
    .re_i(rxf_re_i), .rdata_o(rxf_word_o),
    .empty_o(rxf_empty_o), .full_o(rxf_full)
  );

  // message shape from the latched command words
  assign mode1 = is_mode(cmd1_q.sa);
  assign mdat  = mode1 & cmd1_q.cnt[4];
  always_comb begin
    if (rt2rt_q) begin
      tx_n = '0;
      rx_n = word_count(cmd2_q.cnt);
    end else if (mode1) begin
      tx_n = {5'd0, mdat & ~cmd1_q.tx};
      rx_n = {5'd0, mdat &  cmd1_q.tx};
    end else begin
      tx_n = cmd1_q.tx ? 6'd0 : word_count(cmd1_q.cnt);
      rx_n = cmd1_q.tx ? word_count(cmd1_q.cnt) : 6'd0;
    end
  end
  assign exp_addr = (rt2rt_q && !phase_q) ? cmd2_q.rt : cmd1_q.rt;

  assign start_go = (st_q == S_IDLE) && start_p;

  always_comb begin
    tx_valid_o = 1'b0;
    tx_word_o  = '0;
    tx_csync_o = 1'b0;
    case (st_q)
      S_CMD1: begin tx_valid_o = 1'b1; tx_word_o = cmd1_q; tx_csync_o = 1'b1; end
      S_CMD2: begin tx_valid_o = 1'b1; tx_word_o = cmd2_q; tx_csync_o = 1'b1; end
      S_TXD:  begin tx_valid_o = ~txf_empty; tx_word_o = txf_rdata; end
      default: ;
    endcase
  end

  assign txf_re  = (st_q == S_TXD) && !txf_empty;
  assign rxf_we  = (st_q == S_RXD) && rx_valid_i && !rx_bad_i && !rx_csync_i;
  assign txf_clr = set_ok | set_err;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    phase_d = phase_q;
    set_ok  = 1'b0;
    set_err = 1'b0;
    eset    = '0;
    cap1    = 1'b0;
    cap2    = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (start_p) begin
          st_d    = S_CMD1;
          phase_d = 1'b0;
        end else if (ok_q && rx_valid_i && !rx_csync_i) begin
          set_err          = 1'b1;   // unrequested extra data withdraws the good flag
          eset[EB_WCOUNT]  = 1'b1;
        end
      end
      S_CMD1: begin
        if (rt2rt_q)            st_d = S_CMD2;
        else if (tx_n != 6'd0) begin st_d = S_TXD; cnt_d = tx_n; end
        else                    st_d = S_WSTAT;
      end
      S_CMD2: st_d = S_WSTAT;
      S_TXD: begin
        if (!txf_empty) begin
          cnt_d = cnt_q - 1'b1;
          if (cnt_q == 6'd1) st_d = S_WSTAT;
        end
      end
      S_WSTAT: begin
        if (rx_valid_i) begin
          if (rx_bad_i) begin
            eset[EB_PARITY] = 1'b1; set_err = 1'b1;
          end else if (!rx_csync_i) begin
            eset[EB_CONTIG] = 1'b1; set_err = 1'b1;
          end else begin
            if (rt2rt_q && !phase_q) cap2 = 1'b1;
            else                     cap1 = 1'b1;
            if (rx_word_i[15:11] != exp_addr) begin
              eset[EB_ADDR] = 1'b1; set_err = 1'b1;
            end else if (rt2rt_q && !phase_q) begin
              st_d = S_RXD; cnt_d = rx_n; phase_d = 1'b1;
            end else if (!rt2rt_q && rx_n != 6'd0) begin
              st_d = S_RXD; cnt_d = rx_n;
            end else begin
              set_ok = 1'b1; st_d = S_IDLE;
            end
          end
        end else if (resp_exp) begin
          eset[EB_NORESP] = 1'b1; set_err = 1'b1;
        end
      end
      S_RXD: begin
        if (rx_valid_i) begin
          if (rx_bad_i) begin
            eset[EB_PARITY] = 1'b1; set_err = 1'b1;
          end else if (rx_csync_i) begin
            eset[EB_WCOUNT] = 1'b1; set_err = 1'b1;
          end else begin
            cnt_d = cnt_q - 1'b1;
            if (cnt_q == 6'd1) begin
              if (rt2rt_q) st_d = S_WSTAT;
              else begin set_ok = 1'b1; st_d = S_IDLE; end
            end
          end
        end else if (gap_exp) begin
          eset[EB_CONTIG] = 1'b1; set_err = 1'b1;
        end
      end
      default: st_d = S_IDLE;
    endcase
    if (set_err) st_d = S_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      cnt_q   <= '0;
      phase_q <= 1'b0;
      cmd1_q  <= '0;
      cmd2_q  <= '0;
      rt2rt_q <= 1'b0;
      ok_q    <= 1'b0;
      err_q   <= 1'b0;
      ebits_q <= '0;
      stat1_q <= '0;
      stat2_q <= '0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
      if (start_go) begin
        cmd1_q  <= cmd_word_t'(cmd1_i);
        cmd2_q  <= cmd_word_t'(cmd2_i);
        rt2rt_q <= rt_rt_i;
        ok_q    <= 1'b0;
        err_q   <= 1'b0;
        ebits_q <= '0;
      end else begin
        if (set_ok) ok_q <= 1'b1;
        if (set_err) begin
          ok_q  <= 1'b0;
          err_q <= 1'b1;
        end
        ebits_q <= ebits_q | eset;
      end
      if (cap1) stat1_q <= rx_word_i;
      if (cap2) stat2_q <= rx_word_i;
    end
  end

  assign busy_o    = (st_q != S_IDLE);
  assign msg_ok_o  = ok_q;
  assign msg_err_o = err_q;
  assign err_o     = ebits_q;
  assign stat1_o   = stat1_q;
  assign stat2_o   = stat2_q;

  a_r6_one_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(msg_ok_o && msg_err_o));
  a_r6_quiet_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (!msg_ok_o && !msg_err_o));
  a_r1_first_word_cmd1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (tx_valid_o && tx_csync_o && tx_word_o == cmd1_q));
  a_r12_txf_clear_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(msg_ok_o) |-> txf_empty);
  a_r12_txf_clear_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(msg_err_o) |-> txf_empty);
  a_r10_withdraw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(msg_ok_o) && !busy_o) |-> (msg_err_o && err_o[EB_WCOUNT]));
  a_r13_full_unchanged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rxf_full && !rxf_re_i) |=> !rxf_empty_o);
endmodule

// File: tb/sim_bc_msg_seq.sv
module sim_bc_msg_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 0, start_ctl = 0, rt_rt = 0;
  logic [15:0] cmd1 = '0, cmd2 = '0;
  logic txf_we = 0; logic [15:0] txf_wdata = '0;
  logic txf_full, tx_valid, tx_csync;
  logic [15:0] tx_word;
  logic rx_valid = 0, rx_csync = 0, rx_bad = 0;
  logic [15:0] rx_word = '0;
  logic rxf_re = 0;
  logic [15:0] rxf_word, stat1, stat2;
  logic rxf_empty, busy, msg_ok, msg_err;
  logic [4:0] err;

  int nvec = 0, nfail = 0;
  logic exp_push = 0;
  logic [15:0] mq[$];
  logic [16:0] txq[$];

  always #10 clk = ~clk;

  bc_msg_seq #(.FIFO_DEPTH(32), .RESP_TO(16), .GAP_TO(8)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_ctl_i(start_ctl),
    .rt_rt_i(rt_rt), .cmd1_i(cmd1), .cmd2_i(cmd2),
    .txf_we_i(txf_we), .txf_wdata_i(txf_wdata), .txf_full_o(txf_full),
    .tx_valid_o(tx_valid), .tx_word_o(tx_word), .tx_csync_o(tx_csync),
    .rx_valid_i(rx_valid), .rx_word_i(rx_word), .rx_csync_i(rx_csync), .rx_bad_i(rx_bad),
    .rxf_re_i(rxf_re), .rxf_word_o(rxf_word), .rxf_empty_o(rxf_empty),
    .stat1_o(stat1), .stat2_o(stat2), .busy_o(busy),
    .msg_ok_o(msg_ok), .msg_err_o(msg_err), .err_o(err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // reference receive FIFO
  always @(posedge clk) if (rst_n) begin
    if (rxf_re && mq.size() > 0) void'(mq.pop_front());
    if (rx_valid && exp_push && mq.size() < 32) mq.push_back(rx_word);
  end

  // per-cycle compare and outgoing word capture
  always @(negedge clk) if (rst_n) begin
    if (tx_valid) txq.push_back({tx_csync, tx_word});
    chk("R13 empty flag", int'(rxf_empty), int'(mq.size() == 0));
    if (mq.size() > 0) chk("R3 R13 head word", int'(rxf_word), int'(mq[0]));
  end

  function automatic logic [15:0] cw(input int rt, input int tr, input int sa, input int n);
    return {rt[4:0], tr[0], sa[4:0], n[4:0]};
  endfunction
  function automatic logic [15:0] sw(input int rt);
    return {rt[4:0], 11'h010};
  endfunction

  task automatic idle(input int k); repeat (k) @(negedge clk); endtask
  task automatic pulse_start;
    @(negedge clk) start = 1; @(negedge clk) start = 0;
  endtask
  task automatic tx_push(input logic [15:0] w);
    @(negedge clk) begin txf_we = 1; txf_wdata = w; end
    @(negedge clk) txf_we = 0;
  endtask
  task automatic send(input logic [15:0] w, input bit cs, input bit bad, input bit store);
    @(negedge clk) begin rx_valid = 1; rx_word = w; rx_csync = cs; rx_bad = bad; exp_push = store; end
    @(negedge clk) begin rx_valid = 0; rx_bad = 0; exp_push = 0; end
  endtask
  task automatic wait_tx(input int n);
    for (int i = 0; i < 300 && txq.size() < n; i++) @(negedge clk);
  endtask
  task automatic tx_is(input string tag, input int idx, input bit cs, input logic [15:0] w);
    chk(tag, (txq.size() > idx) ? int'(txq[idx]) : -1, int'({cs, w}));
  endtask
  task automatic flags(input string tag, input int ok, input int er, input int bits);
    chk({tag, " ok"}, int'(msg_ok), ok);
    chk({tag, " err"}, int'(msg_err), er);
    chk({tag, " bits"}, int'(err), bits);
  endtask
  task automatic drain;
    for (int i = 0; i < 80 && mq.size() > 0; i++) begin
      @(negedge clk) rxf_re = 1; @(negedge clk) rxf_re = 0;
    end
  endtask
  task automatic begin_msg(input logic [15:0] c1);
    txq.delete(); cmd1 = c1; pulse_start();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog R6: actual hung expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    chk("R6 reset busy", int'(busy), 0);
    flags("R6 reset", 0, 0, 0);
    chk("R13 reset empty", int'(rxf_empty), 1);

    // R2 receive command, three words, start pin
    tx_push(16'h1111); tx_push(16'h2222); tx_push(16'h3333);
    begin_msg(cw(2, 0, 4, 3));
    wait_tx(4);
    tx_is("R2 cmd1", 0, 1, cw(2, 0, 4, 3));
    tx_is("R2 d0", 1, 0, 16'h1111);
    tx_is("R2 d2", 3, 0, 16'h3333);
    idle(2); send(sw(2), 1, 0, 0); idle(3);
    flags("R2 R6 end", 1, 0, 0);
    chk("R3 stat1", int'(stat1), int'(sw(2)));

    // R3 transmit command, four words, control bit start (R1)
    txq.delete(); cmd1 = cw(3, 1, 2, 4);
    @(negedge clk) start_ctl = 1;
    wait_tx(1);
    tx_is("R1 R3 cmd1", 0, 1, cw(3, 1, 2, 4));
    chk("R1 single cmd", txq.size(), 1);
    idle(2); send(sw(3), 1, 0, 0);
    for (int i = 0; i < 4; i++) send(16'hA000 + 16'(i), 0, 0, 1);
    idle(3);
    flags("R3 end", 1, 0, 0);
    chk("R3 rx count", mq.size(), 4);
    drain();

    // R1 held control bit does not restart
    txq.delete(); idle(20);
    chk("R1 held level", txq.size(), 0);
    chk("R1 held busy", int'(busy), 0);
    @(negedge clk) start_ctl = 0;

    // R4 mode code with data, receive side
    tx_push(16'h5A5A);
    txq.delete(); cmd1 = cw(4, 0, 0, 17);
    @(negedge clk) start_ctl = 1;
    wait_tx(2);
    tx_is("R4 mode rx cmd", 0, 1, cw(4, 0, 0, 17));
    tx_is("R4 mode rx data", 1, 0, 16'h5A5A);
    idle(2); send(sw(4), 1, 0, 0); idle(3);
    flags("R4 mode rx", 1, 0, 0);
    @(negedge clk) start_ctl = 0;

    // R4 mode code with data, transmit side
    begin_msg(cw(4, 1, 31, 18));
    wait_tx(1); idle(2);
    send(sw(4), 1, 0, 0); send(16'hBEEF, 0, 0, 1); idle(3);
    flags("R4 mode tx", 1, 0, 0);
    chk("R4 mode tx stored", mq.size(), 1);
    chk("R4 mode tx words", txq.size(), 1);
    drain();

    // R4 mode code without data
    begin_msg(cw(4, 1, 0, 2));
    wait_tx(1); idle(2); send(sw(4), 1, 0, 0); idle(3);
    flags("R4 mode nodata", 1, 0, 0);
    chk("R4 mode nodata empty", int'(rxf_empty), 1);

    // R5 terminal to terminal
    rt_rt = 1; cmd2 = cw(9, 1, 7, 2);
    begin_msg(cw(5, 0, 3, 2));
    wait_tx(2);
    tx_is("R5 cmd1", 0, 1, cw(5, 0, 3, 2));
    tx_is("R5 cmd2", 1, 1, cw(9, 1, 7, 2));
    idle(2);
    send(sw(9), 1, 0, 0); send(16'h0C01, 0, 0, 1); send(16'h0C02, 0, 0, 1);
    idle(2); chk("R5 busy before 2nd status", int'(busy), 1);
    send(sw(5), 1, 0, 0); idle(3);
    flags("R5 end", 1, 0, 0);
    chk("R5 stat2", int'(stat2), int'(sw(9)));
    chk("R5 stat1", int'(stat1), int'(sw(5)));
    rt_rt = 0; drain();

    // R7 no response
    begin_msg(cw(3, 1, 2, 2));
    wait_tx(1); idle(40);
    flags("R7 noresp", 0, 1, 1);

    // R8 parity on status
    begin_msg(cw(3, 1, 2, 2));
    wait_tx(1); idle(2); send(sw(3), 1, 1, 0); idle(3);
    flags("R8 parity", 0, 1, 2);

    // R9 address mismatch
    begin_msg(cw(3, 1, 2, 2));
    wait_tx(1); idle(2); send(sw(7), 1, 0, 0); idle(3);
    flags("R9 addr", 0, 1, 8);
    chk("R9 captured", int'(stat1), int'(sw(7)));

    // R10 fewer words: status sync where data due
    begin_msg(cw(3, 1, 2, 3));
    wait_tx(1); idle(2);
    send(sw(3), 1, 0, 0); send(16'h0101, 0, 0, 1); send(sw(3), 1, 0, 0); idle(3);
    flags("R10 short", 0, 1, 4);
    drain();

    // R10 extra word withdraws the good flag
    begin_msg(cw(3, 1, 2, 2));
    wait_tx(1); idle(2);
    send(sw(3), 1, 0, 0); send(16'h0201, 0, 0, 1); send(16'h0202, 0, 0, 1); idle(3);
    flags("R10 before extra", 1, 0, 0);
    send(16'h0203, 0, 0, 0); idle(2);
    flags("R10 R6 withdrawn", 0, 1, 4);
    chk("R10 extra not stored", mq.size(), 2);
    drain();

    // R11 gap in data
    begin_msg(cw(3, 1, 2, 2));
    wait_tx(1); idle(2);
    send(sw(3), 1, 0, 0); send(16'h0301, 0, 0, 1); idle(30);
    flags("R11 gap", 0, 1, 16);
    drain();

    // R11 data sync where status due
    begin_msg(cw(3, 1, 2, 2));
    wait_tx(1); idle(2); send(16'h0400, 0, 0, 0); idle(3);
    flags("R11 wrong sync", 0, 1, 16);

    // R12 leftovers discarded at end flag
    tx_push(16'hAAAA); tx_push(16'hBBBB); tx_push(16'hCCCC);
    begin_msg(cw(6, 0, 4, 1));
    wait_tx(2); idle(2); send(sw(6), 1, 0, 0); idle(3);
    flags("R12 first", 1, 0, 0);
    tx_push(16'hDDDD);
    begin_msg(cw(6, 0, 4, 1));
    wait_tx(2);
    tx_is("R12 fresh word", 1, 0, 16'hDDDD);
    idle(2); send(sw(6), 1, 0, 0); idle(3);

    // R2 stall on empty transmit FIFO
    begin_msg(cw(6, 0, 4, 2));
    wait_tx(1); idle(10);
    chk("R2 stall words", txq.size(), 1);
    chk("R2 stall busy", int'(busy), 1);
    tx_push(16'hE001); tx_push(16'hE002);
    wait_tx(3);
    tx_is("R2 after stall", 2, 0, 16'hE002);
    idle(2); send(sw(6), 1, 0, 0); idle(3);
    flags("R2 stall end", 1, 0, 0);

    // R2 count field 0 means 32
    for (int i = 0; i < 32; i++) tx_push(16'h7000 + 16'(i));
    chk("R2 txf full", int'(txf_full), 1);
    begin_msg(cw(2, 0, 4, 0));
    wait_tx(33); idle(1);
    chk("R2 32 words", txq.size(), 33);
    tx_is("R2 last of 32", 32, 0, 16'h701F);
    idle(1); send(sw(2), 1, 0, 0); idle(3);
    flags("R2 32 end", 1, 0, 0);

    // R13 full receive FIFO drops new words
    for (int m = 0; m < 2; m++) begin
      begin_msg(cw(3, 1, 2, 0));
      wait_tx(1); idle(2); send(sw(3), 1, 0, 0);
      for (int i = 0; i < 32; i++) send(16'(m * 256 + i), 0, 0, 1);
      idle(3);
      flags("R13 full msg", 1, 0, 0);
    end
    chk("R13 model count", mq.size(), 32);
    chk("R13 head after drop", int'(rxf_word), 0);
    drain();
    idle(2);
    chk("R13 drained", int'(rxf_empty), 1);

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule